// File: doc/BRIEF.md
# Single-Channel Descriptor DMA Controller

This block is one DMA channel that software programs through a 32-bit register window. The window holds a command/status word and a bank of address pointers: a live current pointer and end pointer, a pending start/stop pair for a follow-on buffer, an initial-buffer word, a size word, and read-only snapshots of the four pointers taken when a buffer finishes. The command/status word is asymmetric. Writes carry one-shot command bits. Reads return a separate set of status flags.

Once the channel is enabled, a transfer engine moves one 32-bit word per cycle. It moves words either from a device-side valid/ready stream into a memory request port, or from the memory port out to a device-side stream. Each accepted word is placed at the current pointer, and the pointer then advances by one word. When the pointer arrives at the end pointer, the channel does one of two things. If the chain flag is armed, it swaps in the pending start/stop pair and keeps running. Otherwise it stops, marks itself complete and pulses an interrupt.

Top module: `dmach_top`

## Requirements
- R1: Only accesses with `reg_size` equal to 4 are acted on. A write of any other size changes nothing, and a read of any other size returns 0. A 4-byte read of an offset that maps to no register also returns 0.
- R2: The 4-byte registers at the following offsets are readable and writable: current pointer 0x4000, end pointer 0x4004, start 0x4008, stop 0x400C, initial-buffer 0x4200, size 0x4204. The snapshots of current, end, start and stop sit at 0x3FF0, 0x3FF4, 0x3FF8 and 0x3FFC. The snapshots are read-only, and writes to them are ignored. Every register resets to 0.
- R3: The command/status word sits at offset 0x0. Writing bit 16 sets the enable flag. Writing bit 17 sets the chain flag. Writing bit 18 sets the direction flag (1 means device to memory, 0 means memory to device). Writing bit 19 clears the complete flag. A command bit written as 0 leaves its flag unchanged. On read, the enable flag is at bit 24, chain at bit 25, direction at bit 26 and complete at bit 27, and every other bit reads 0.
- R4: Writing bit 20 clears enable, chain, direction and complete together. It takes priority over any set bit written in the same word.
- R5: While enable and direction are both 1, each cycle with `dev_in_valid` and `mem_gnt` high writes `dev_in_data` to `mem_addr`, which equals the current pointer. The current pointer then advances by 4.
- R6: While enable is 1 and direction is 0, the block requests a memory read at the current pointer. Each cycle with `mem_gnt` and `dev_out_ready` high passes `mem_rdata` out on `dev_out_data`, and the current pointer advances by 4.
- R7: When a word moves the current pointer onto the end pointer and chain is 0, enable clears and complete sets. `irq` is high for exactly the one following cycle. The snapshots then hold the final current pointer and the end, start and stop pointers.
- R8: When a word moves the current pointer onto the end pointer and chain is 1, start and stop are loaded into the current and end pointers, and chain clears. The transfer continues with no interrupt and without setting complete.
- R9: While enable is 0, `mem_req` stays 0 and no word is accepted on either stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | ADDR_W | Byte offset in the register window |
| reg_size | input | 3 | Access size in bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| dev_in_valid | input | 1 | Device word available (device to memory) |
| dev_in_data | input | 32 | Device word |
| dev_in_ready | output | 1 | Device word taken |
| dev_out_valid | output | 1 | Word presented to the device (memory to device) |
| dev_out_data | output | 32 | Word to the device |
| dev_out_ready | input | 1 | Device can take a word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Memory read data, valid with the grant |
| irq | output | 1 | One-cycle completion pulse |

## Verification
The bench targets four kinds of corner case.

- **Register window.** It sweeps every mapped offset, several unmapped ones and the non-word sizes. A decoder that ignored the size would corrupt a pointer on a byte write. A decoder that aliased offsets would return stale data where 0 is expected.
- **Command/status split.** It writes each command bit on its own, then writes reset together with set-enable. A design that reused the command positions for status would read back garbage at bits 16–20. A design that let enable win the tie would begin issuing memory requests.
- **Stop on the end pointer.** It runs one transfer with a grant that toggles every cycle. A wrong boundary compare would move one word too many or too few.
- **Chain hand-off.** It runs one transfer that chains into a second buffer. A design that failed to reload would stop early with a premature interrupt. A design that failed to clear chain would loop on the same buffer forever.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  // command bits (write side of the control word)
  localparam int CMD_SET_EN    = 16;
  localparam int CMD_SET_CHAIN = 17;
  localparam int CMD_SET_DIR   = 18;
  localparam int CMD_CLR_DONE  = 19;
  localparam int CMD_RESET     = 20;

  // status bits (read side of the control word)
  localparam int ST_EN    = 24;
  localparam int ST_CHAIN = 25;
  localparam int ST_DIR   = 26;
  localparam int ST_DONE  = 27;

  typedef struct packed {
    logic done;
    logic dir;
    logic chain;
    logic en;
  } chan_flags_t;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CSR,
    SEL_NEXT, SEL_LIMIT, SEL_START, SEL_STOP,
    SEL_SNEXT, SEL_SLIMIT, SEL_SSTART, SEL_SSTOP,
    SEL_INIT, SEL_SIZE
  } reg_sel_t;

  function automatic reg_sel_t decode_offset(input logic [31:0] off);
    case (off)
      32'h0000_0000: return SEL_CSR;
      32'h0000_4000: return SEL_NEXT;
      32'h0000_4004: return SEL_LIMIT;
      32'h0000_4008: return SEL_START;
      32'h0000_400C: return SEL_STOP;
      32'h0000_3FF0: return SEL_SNEXT;
      32'h0000_3FF4: return SEL_SLIMIT;
      32'h0000_3FF8: return SEL_SSTART;
      32'h0000_3FFC: return SEL_SSTOP;
      32'h0000_4200: return SEL_INIT;
      32'h0000_4204: return SEL_SIZE;
      default:       return SEL_NONE;
    endcase
  endfunction

  function automatic reg_sel_t live_code(input int idx);
    case (idx)
      0:       return SEL_NEXT;
      1:       return SEL_LIMIT;
      2:       return SEL_START;
      default: return SEL_STOP;
    endcase
  endfunction

  function automatic reg_sel_t saved_code(input int idx);
    case (idx)
      0:       return SEL_SNEXT;
      1:       return SEL_SLIMIT;
      2:       return SEL_SSTART;
      default: return SEL_SSTOP;
    endcase
  endfunction

  function automatic logic [31:0] ptr_step(input logic [31:0] p, input int unsigned step);
    return p + 32'(step);
  endfunction

  function automatic logic [31:0] status_word(input chan_flags_t f);
    logic [31:0] w;
    w = '0;
    w[ST_EN]    = f.en;
    w[ST_CHAIN] = f.chain;
    w[ST_DIR]   = f.dir;
    w[ST_DONE]  = f.done;
    return w;
  endfunction

endpackage

// File: rtl/dmach_csr.sv
module dmach_csr
  import dmach_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic        term_evt,
  input  logic        chain_evt,
  output chan_flags_t flags
);
  chan_flags_t flags_d;

  always_comb begin
    flags_d = flags;
    if (term_evt) begin
      flags_d.en   = 1'b0;
      flags_d.done = 1'b1;
    end
    if (chain_evt) flags_d.chain = 1'b0;
    if (cmd_wr) begin
      if (cmd_word[CMD_SET_EN])    flags_d.en    = 1'b1;
      if (cmd_word[CMD_SET_CHAIN]) flags_d.chain = 1'b1;
      if (cmd_word[CMD_SET_DIR])   flags_d.dir   = 1'b1;
      if (cmd_word[CMD_CLR_DONE])  flags_d.done  = 1'b0;
      if (cmd_word[CMD_RESET])     flags_d       = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  // R4
  reset_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_word[CMD_RESET] |=> flags == '0);

  // R3
  set_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && cmd_word[CMD_SET_EN] && !cmd_word[CMD_RESET] |=> flags.en);

  // R7
  stop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt && !cmd_wr |=> flags.done && !flags.en);

endmodule

// File: rtl/dmach_ptrs.sv
module dmach_ptrs
  import dmach_pkg::*;
#(
  parameter int PTR_W      = 32,
  parameter int STEP_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  reg_sel_t         wr_sel,
  input  logic [PTR_W-1:0] wr_data,
  input  logic             beat,
  input  logic             chain_on,
  input  reg_sel_t         rd_sel,
  output logic [PTR_W-1:0] next_ptr,
  output logic             stop_evt,
  output logic             chain_evt,
  output logic             term_evt,
  output logic [PTR_W-1:0] rd_data
);
  localparam int NPTR = 4;

  logic [PTR_W-1:0] live  [NPTR];
  logic [PTR_W-1:0] saved [NPTR];
  logic [PTR_W-1:0] init_q, size_q, next_adv;
  logic [NPTR-1:0]  live_wr;

  assign next_adv  = ptr_step(live[0], STEP_BYTES);
  assign stop_evt  = beat && (next_adv == live[1]);
  assign chain_evt = stop_evt && chain_on;
  assign term_evt  = stop_evt && !chain_on;
  assign next_ptr  = live[0];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    assign live_wr[i] = wr_en && (wr_sel == live_code(i));

    if (i == 0) begin : g_cur
      always_ff @(posedge clk) begin
        if (!rst_n)         live[i] <= '0;
        else if (live_wr[i]) live[i] <= wr_data;
        else if (chain_evt)  live[i] <= live[i+2];
        else if (beat)       live[i] <= next_adv;
      end
    end else if (i == 1) begin : g_end
      always_ff @(posedge clk) begin
        if (!rst_n)         live[i] <= '0;
        else if (live_wr[i]) live[i] <= wr_data;
        else if (chain_evt)  live[i] <= live[i+2];
      end
    end else begin : g_pend
      always_ff @(posedge clk) begin
        if (!rst_n)         live[i] <= '0;
        else if (live_wr[i]) live[i] <= wr_data;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)        saved[i] <= '0;
      else if (stop_evt) saved[i] <= (i == 0) ? next_adv : live[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_INIT) init_q <= wr_data;
      if (wr_sel == SEL_SIZE) size_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_NEXT:   rd_data = live[0];
      SEL_LIMIT:  rd_data = live[1];
      SEL_START:  rd_data = live[2];
      SEL_STOP:   rd_data = live[3];
      SEL_SNEXT:  rd_data = saved[0];
      SEL_SLIMIT: rd_data = saved[1];
      SEL_SSTART: rd_data = saved[2];
      SEL_SSTOP:  rd_data = saved[3];
      SEL_INIT:   rd_data = init_q;
      SEL_SIZE:   rd_data = size_q;
      default:    rd_data = '0;
    endcase
  end

  // R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !stop_evt && !live_wr[0] |=> live[0] == $past(live[0]) + PTR_W'(STEP_BYTES));

  // R8
  chain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chain_evt && !(|live_wr) |=> live[0] == $past(live[2]) && live[1] == $past(live[3]));

endmodule

// File: rtl/dmach_port.sv
module dmach_port #(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 32
) (
  input  logic              en,
  input  logic              dir,
  input  logic [PTR_W-1:0]  next_ptr,
  input  logic              dev_in_valid,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [DATA_W-1:0] dev_out_data,
  input  logic              dev_out_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              beat
);
  logic to_mem, to_dev;

  assign to_mem        = en && dir;
  assign to_dev        = en && !dir;
  assign mem_req       = (to_mem && dev_in_valid) || (to_dev && dev_out_ready);
  assign mem_we        = to_mem;
  assign mem_addr      = next_ptr;
  assign mem_wdata     = dev_in_data;
  assign dev_in_ready  = to_mem && mem_gnt;
  assign dev_out_valid = to_dev && mem_gnt;
  assign dev_out_data  = mem_rdata;
  assign beat          = mem_req && mem_gnt;

endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int STEP_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [2:0]        reg_size,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_in_valid,
  input  logic [31:0]       dev_in_data,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [31:0]       dev_out_data,
  input  logic              dev_out_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_gnt,
  input  logic [31:0]       mem_rdata,
  output logic              irq
);
  localparam int WORD_W = 32;
  localparam logic [2:0] WORD_BYTES = 3'(WORD_W / 8);

  logic        acc_ok, wr_stb, cmd_wr, beat;
  logic        stop_evt, chain_evt, term_evt;
  reg_sel_t    hit;
  chan_flags_t flags;
  logic [31:0] next_ptr, ptr_rd;

  assign acc_ok = reg_sel && (reg_size == WORD_BYTES);
  assign hit    = decode_offset(32'(reg_addr));
  assign wr_stb = acc_ok && reg_we;
  assign cmd_wr = wr_stb && (hit == SEL_CSR);

  dmach_csr u_csr (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(reg_wdata),
    .term_evt(term_evt), .chain_evt(chain_evt), .flags(flags)
  );

  dmach_ptrs #(.PTR_W(WORD_W), .STEP_BYTES(STEP_BYTES)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_stb), .wr_sel(hit), .wr_data(reg_wdata),
    .beat(beat), .chain_on(flags.chain), .rd_sel(hit), .next_ptr(next_ptr),
    .stop_evt(stop_evt), .chain_evt(chain_evt), .term_evt(term_evt), .rd_data(ptr_rd)
  );

  dmach_port #(.DATA_W(WORD_W), .PTR_W(WORD_W)) u_port (
    .en(flags.en), .dir(flags.dir), .next_ptr(next_ptr),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .beat(beat)
  );

  always_comb begin
    reg_rdata = '0;
    if (acc_ok && !reg_we) begin
      if (hit == SEL_CSR) reg_rdata = status_word(flags);
      else                reg_rdata = ptr_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= term_evt;
  end

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.en |-> !mem_req && !dev_in_ready && !dev_out_valid);

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_evt |=> irq);

endmodule

// File: tb/tb_dmach_top.sv
module tb_dmach_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [2:0]  reg_size = 3'd4;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        dev_in_valid = 1'b0, dev_in_ready;
  logic [31:0] dev_in_data;
  logic        dev_out_valid, dev_out_ready = 1'b0;
  logic [31:0] dev_out_data;
  logic        mem_req, mem_we, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_gnt;
  logic        gnt_level = 1'b0, gnt_toggle = 1'b0, tog = 1'b0;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, irq_cnt = 0;
  logic [31:0] wr_addr [16];
  logic [31:0] wr_data [16];
  logic [31:0] rd_addr [16];
  logic [31:0] rd_data [16];
  logic [15:0] seq = '0;

  always #2.5 clk = ~clk;

  assign mem_gnt     = gnt_toggle ? tog : gnt_level;
  assign mem_rdata   = mem_addr ^ 32'h5A5A_0000;
  assign dev_in_data = 32'hC0DE_0000 | {16'h0, seq};

  always @(negedge clk) tog <= ~tog;

  always @(posedge clk) begin
    if (irq) irq_cnt <= irq_cnt + 1;
    if (mem_req && mem_gnt && mem_we && dev_in_ready) begin
      if (wr_cnt < 16) begin
        wr_addr[wr_cnt] <= mem_addr;
        wr_data[wr_cnt] <= mem_wdata;
      end
      wr_cnt <= wr_cnt + 1;
      seq <= seq + 16'd1;
    end
    if (dev_out_valid && dev_out_ready) begin
      if (rd_cnt < 16) begin
        rd_addr[rd_cnt] <= mem_addr;
        rd_data[rd_cnt] <= dev_out_data;
      end
      rd_cnt <= rd_cnt + 1;
    end
  end

  dmach_top dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data), .dev_out_ready(dev_out_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_size = sz;
    @(posedge clk);
    #1 reg_sel = 1'b0; reg_we = 1'b0; reg_size = 3'd4;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a; reg_size = sz;
    #1 d = reg_rdata;
    reg_sel = 1'b0; reg_size = 3'd4;
  endtask

  task automatic rdchk(input string tag, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic run_all();
    logic [31:0] d;
    logic [15:0] rw_offs [6];
    logic [15:0] sv_offs [4];
    logic [15:0] bad_offs [5];
    int irq0;
    rw_offs = '{16'h4000, 16'h4004, 16'h4008, 16'h400C, 16'h4200, 16'h4204};
    sv_offs = '{16'h3FF0, 16'h3FF4, 16'h3FF8, 16'h3FFC};
    bad_offs = '{16'h0004, 16'h4010, 16'h4208, 16'h3FEC, 16'h4001};

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset irq", {31'h0, irq}, 32'h0);
    rdchk("R3 reset status", 16'h0000, 32'h0);
    for (int i = 0; i < 6; i++) rdchk("R2 reset pointer", rw_offs[i], 32'h0);

    // R2 register sweep
    for (int i = 0; i < 6; i++) wr(rw_offs[i], 32'h1000 * (i + 1) + 32'h10 * i);
    for (int i = 0; i < 6; i++) rdchk("R2 readback", rw_offs[i], 32'h1000 * (i + 1) + 32'h10 * i);
    for (int i = 0; i < 4; i++) begin
      wr(sv_offs[i], 32'hDEAD_BEEF);
      rdchk("R2 snapshot read-only", sv_offs[i], 32'h0);
    end

    // R1 size filter and unmapped offsets
    wr(16'h4000, 32'hFFFF_FFFF, 3'd2);
    wr(16'h4004, 32'hFFFF_FFFF, 3'd1);
    rdchk("R1 halfword write ignored", 16'h4000, 32'h1000);
    rdchk("R1 byte write ignored", 16'h4004, 32'h2010);
    rd(16'h4000, d, 3'd1);
    chk("R1 byte read zero", d, 32'h0);
    rd(16'h4008, d, 3'd2);
    chk("R1 halfword read zero", d, 32'h0);
    for (int i = 0; i < 5; i++) begin
      wr(bad_offs[i], 32'h1234_5678);
      rdchk("R1 unmapped zero", bad_offs[i], 32'h0);
    end

    // R3 individual command bits
    wr(16'h0000, 32'h1 << 17);
    rdchk("R3 set chain", 16'h0000, 32'h1 << 25);
    wr(16'h0000, 32'h1 << 18);
    rdchk("R3 set dir", 16'h0000, (32'h1 << 25) | (32'h1 << 26));
    wr(16'h0000, 32'h0);
    rdchk("R3 zero command no effect", 16'h0000, (32'h1 << 25) | (32'h1 << 26));
    // R4 reset clears all
    wr(16'h0000, 32'h1 << 20);
    rdchk("R4 reset clears", 16'h0000, 32'h0);
    // R4 reset beats set-enable
    wr(16'h0000, (32'h1 << 20) | (32'h1 << 16) | (32'h1 << 17));
    rdchk("R4 reset priority", 16'h0000, 32'h0);

    // R9 idle: no request while disabled
    dev_in_valid = 1'b1; dev_out_ready = 1'b1; gnt_level = 1'b1;
    repeat (4) @(negedge clk);
    #1 chk("R9 no mem_req while disabled", {31'h0, mem_req}, 32'h0);
    chk("R9 no beats while disabled", wr_cnt + rd_cnt, 0);
    dev_in_valid = 1'b0; dev_out_ready = 1'b0; gnt_level = 1'b0;

    // R5/R7 device to memory, grant toggling
    irq0 = irq_cnt;
    wr(16'h4000, 32'h0000_0100);
    wr(16'h4004, 32'h0000_0110);
    wr(16'h0000, (32'h1 << 18) | (32'h1 << 16));
    gnt_toggle = 1'b1; dev_in_valid = 1'b1;
    repeat (20) @(negedge clk);
    dev_in_valid = 1'b0; gnt_toggle = 1'b0;
    chk("R5 word count", wr_cnt, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R5 address", wr_addr[k], 32'h100 + 32'(4 * k));
      chk("R5 data", wr_data[k], 32'hC0DE_0000 | 32'(k));
    end
    rdchk("R7 status done", 16'h0000, (32'h1 << 27) | (32'h1 << 26));
    chk("R7 one irq", irq_cnt - irq0, 1);
    rdchk("R5 pointer at end", 16'h4000, 32'h110);
    rdchk("R7 snapshot cur", 16'h3FF0, 32'h110);
    rdchk("R7 snapshot end", 16'h3FF4, 32'h110);
    rdchk("R7 snapshot start", 16'h3FF8, 32'h3020);
    wr(16'h0000, 32'h1 << 19);
    rdchk("R3 clear done", 16'h0000, 32'h1 << 26);

    // R9 after stop: stream held valid, no further words
    dev_in_valid = 1'b1; gnt_level = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R9 no request after stop", {31'h0, mem_req}, 32'h0);
    dev_in_valid = 1'b0; gnt_level = 1'b0;
    chk("R9 count unchanged", wr_cnt, 4);

    // R6/R8 memory to device with chain
    wr(16'h0000, 32'h1 << 20);
    irq0 = irq_cnt;
    wr(16'h4000, 32'h0000_0200);
    wr(16'h4004, 32'h0000_0208);
    wr(16'h4008, 32'h0000_0300);
    wr(16'h400C, 32'h0000_030C);
    wr(16'h0000, 32'h1 << 17);
    rdchk("R8 chain armed", 16'h0000, 32'h1 << 25);
    gnt_level = 1'b1; dev_out_ready = 1'b1;
    wr(16'h0000, 32'h1 << 16);
    repeat (20) @(negedge clk);
    dev_out_ready = 1'b0; gnt_level = 1'b0;
    chk("R8 total words", rd_cnt, 5);
    for (int k = 0; k < 5; k++) begin
      logic [31:0] ea;
      ea = (k < 2) ? 32'h200 + 32'(4 * k) : 32'h300 + 32'(4 * (k - 2));
      chk("R6 address", rd_addr[k], ea);
      chk("R6 data", rd_data[k], ea ^ 32'h5A5A_0000);
    end
    rdchk("R8 chain cleared, done", 16'h0000, 32'h1 << 27);
    chk("R8 one irq over both buffers", irq_cnt - irq0, 1);
    rdchk("R8 cur reloaded", 16'h4000, 32'h30C);
    rdchk("R8 end reloaded", 16'h4004, 32'h30C);
    rdchk("R7 snapshot cur final", 16'h3FF0, 32'h30C);
    rdchk("R7 snapshot stop final", 16'h3FFC, 32'h30C);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule